// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for the two-wire station management interface used by Ethernet PHYs (clock line MDC and bidirectional data line MDIO, short-frame format). Software sees two 32-bit registers on a simple write-strobe register port. The control register at offset 0x0 holds the MDC divider and a preamble enable, and reports a busy flag. The data register at offset 0x4 holds one complete management frame exactly as it appears on the wire.

Writing the data register while the controller is idle starts a transaction. The controller optionally sends a run of ones as preamble. It then shifts the 32-bit word out most significant bit first, with MDC generated from the divider. On a read opcode it releases MDIO for the turnaround and data phase and captures the bits returned by the PHY into the low half of the same register. When busy clears, software reads the result from offset 0x4.

Top module: `mdio_master`

## Requirements
- R1: After reset, the control register reads 0x0000001A: divider field bits [6:0] = 0x1A, preamble enable bit 7 = 0, busy bit 8 = 0. MDC is low and the MDIO output enable is low.
- R2: A write to offset 0x0 sets the divider from bits [6:0] and the preamble enable from bit 7, and both read back at those positions. Bit 8 is read-only: writing it does not set busy.
- R3: A write to offset 0x4 while idle starts a frame. Busy (control bit 8) then reads 1 for exactly NBITS×2×(divider+1) clock cycles, where NBITS is 64 with preamble and 32 without.
- R4: The MDC period is 2×(divider+1) clock cycles. MDC is low for the first half of each bit and rises in the middle of the bit. Data leaves on the falling edge and is sampled on the rising edge.
- R5: With preamble enabled, 32 consecutive 1 bits are driven before the frame word. With preamble disabled, the frame word starts immediately.
- R6: The frame word is driven from bit 31 down to bit 0, one bit per MDC cycle. For a write the PHY sees exactly the 32 bits written: start 01 in [31:30], opcode in [29:28], PHY address in [27:23], register address in [22:18], turnaround 10 in [17:16], data in [15:0].
- R7: When opcode bits [29:28] = 10 (read), the output enable is low from frame bit 16 through bit 0. The 16 bits sampled during bits 15..0 replace data register bits [15:0], MSB first, and bits [31:16] keep their written value.
- R8: A write to offset 0x4 while busy is ignored: the frame in progress and the data register contents are unchanged, and no second frame follows.
- R9: When no frame is active, MDC is low and MDIO is released (output enable low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset: 0x0 control, 0x4 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the block with its default parameters: a 7-bit divider resetting to 0x1A and a 32-bit preamble. It reaches the divider settings of interest by writing the control register. It runs frames with divider 0, 1, 2 and the reset value 0x1A, so the shortest MDC period (two clocks) and the slow default period are both measured. A PHY model in the bench counts MDC edges, records every driven bit and answers read frames. This makes the preamble length, the turnaround release point and the placement of the read data directly observable at the pins and in the data register.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W   = 7,
  parameter int DIV_RST = 26,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wen,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int TOT   = PRE_LEN + 32;
  localparam int POS_W = $clog2(TOT);

  logic [DIV_W-1:0] div_q, cnt;
  logic             pre_q, busy, mdc_q;
  logic [POS_W-1:0] pos;
  logic [31:0]      frame;

  wire ctrl_wr = reg_wen && reg_addr == 3'h0;
  wire data_wr = reg_wen && reg_addr == 3'h4;
  wire tick    = cnt >= div_q;
  wire rd_op   = frame[29:28] == 2'b10;
  wire in_pre  = pos >= POS_W'(32);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(DIV_RST);
      pre_q <= 1'b0;
      busy  <= 1'b0;
      mdc_q <= 1'b0;
      cnt   <= '0;
      pos   <= '0;
      frame <= '0;
    end else begin
      if (ctrl_wr) begin
        div_q <= reg_wdata[DIV_W-1:0];
        pre_q <= reg_wdata[7];
      end
      if (!busy) begin
        if (data_wr) begin
          frame <= reg_wdata;
          busy  <= 1'b1;
          pos   <= pre_q ? POS_W'(TOT - 1) : POS_W'(31);
          cnt   <= '0;
          mdc_q <= 1'b0;
        end
      end else if (tick) begin
        cnt   <= '0;
        mdc_q <= ~mdc_q;
        if (!mdc_q) begin
          if (rd_op && pos < POS_W'(16)) frame[pos[4:0]] <= mdio_i;
        end else if (pos == '0) begin
          busy <= 1'b0;
        end else begin
          pos <= pos - 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = busy && (in_pre || frame[pos[4:0]]);
  assign mdio_oe = busy && !(rd_op && pos <= POS_W'(16));

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 3'h0) begin
      reg_rdata[DIV_W-1:0] = div_q;
      reg_rdata[7]         = pre_q;
      reg_rdata[8]         = busy;
    end else if (reg_addr == 3'h4) begin
      reg_rdata = frame;
    end
  end

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc && !mdio_oe);
  p_mdc_only_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc) |-> $past(busy));
  p_release_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_op && pos < POS_W'(16) |-> !mdio_oe);
  p_preamble_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && in_pre |-> mdio_oe && mdio_o);
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && data_wr && !(tick && mdc_q) |=> $stable(pos));
  p_busy_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && ctrl_wr && !data_wr |=> !busy);
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        reg_wen = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 0;

  int checks = 0, errors = 0;
  int rises = 0, ncap = 0, nrel = 0, pre_off = 0;
  int clk_since = 0, last_per = 0;
  logic [63:0] cap = 0;
  logic [15:0] phy_val = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mdio_master dut_i (.clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always @(posedge clk) clk_since <= clk_since + 1;

  always @(posedge mdc) begin
    last_per  = clk_since;
    clk_since = 0;
    rises++;
    if (mdio_oe) begin cap = {cap[62:0], mdio_o}; ncap++; end
    else nrel++;
  end

  always @(negedge mdc) begin
    int p;
    p = 31 - (rises - pre_off);
    if (p >= 0 && p < 16) mdio_i = phy_val[p];
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wen = 0; reg_addr = 0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    forever begin
      #1;
      if (!reg_rdata[8] || n > 100000) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic clear_phy(bit pre, logic [15:0] v);
    rises = 0; ncap = 0; nrel = 0; cap = 0;
    pre_off = pre ? 32 : 0; phy_val = v;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(3'h0, d);
    chk("R1 ctrl reset", d, 32'h1A);
    chk("R1 mdc reset", mdc, 0);
    chk("R9 oe idle", mdio_oe, 0);
  endtask

  task automatic t_ctrl_fields;
    logic [31:0] d;
    bus_write(3'h0, 32'h0000_0185);
    bus_read(3'h0, d);
    chk("R2 ctrl readback busy ro", d, 32'h85);
  endtask

  task automatic t_write(bit pre, int div, logic [31:0] w);
    int n, nb;
    logic [31:0] d;
    logic [63:0] exp;
    nb = pre ? 64 : 32;
    bus_write(3'h0, {24'h0, pre, 7'(div)});
    clear_phy(pre, 16'h0);
    bus_write(3'h4, w);
    wait_idle(n);
    chk("R3 busy cycles", n, nb * 2 * (div + 1));
    chk("R4 mdc period", last_per, 2 * (div + 1));
    chk("R6 mdc cycles", rises, nb);
    chk("R6 driven count", ncap, nb);
    exp = pre ? {32'hFFFF_FFFF, w} : {32'h0, w};
    chk(pre ? "R5 preamble+frame bits" : "R6 frame bits", cap, exp);
    bus_read(3'h4, d);
    chk("R6 data readback", d, w);
    chk("R9 mdc low after", mdc, 0);
    chk("R9 oe low after", mdio_oe, 0);
  endtask

  task automatic t_read(bit pre, int div, logic [31:0] w, logic [15:0] v);
    int n, nb;
    logic [31:0] d;
    nb = pre ? 64 : 32;
    bus_write(3'h0, {24'h0, pre, 7'(div)});
    clear_phy(pre, v);
    bus_write(3'h4, w);
    wait_idle(n);
    chk("R3 read busy cycles", n, nb * 2 * (div + 1));
    chk("R7 driven bits", ncap, nb - 17);
    chk("R7 released bits", nrel, 17);
    chk("R7 header bits", cap[14:0], w[31:17]);
    if (pre) chk("R5 preamble before read", cap[46:15], 32'hFFFF_FFFF);
    bus_read(3'h4, d);
    chk("R7 read data", d, {w[31:16], v});
  endtask

  task automatic t_busy_ignore(logic [31:0] w1, logic [31:0] w2);
    int n;
    logic [31:0] d;
    bus_write(3'h0, 32'h3);
    clear_phy(0, 16'h0);
    bus_write(3'h4, w1);
    repeat (10) @(negedge clk);
    bus_write(3'h4, w2);
    wait_idle(n);
    repeat (100) @(negedge clk);
    chk("R8 single frame", rises, 32);
    chk("R8 bits unchanged", cap[31:0], w1);
    bus_read(3'h4, d);
    chk("R8 data unchanged", d, w1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl_fields();
    t_write(0, 2, {2'b01, 2'b01, 5'd3, 5'd9, 2'b10, 16'hA5C3});
    t_write(1, 0, {2'b01, 2'b01, 5'd17, 5'd30, 2'b10, 16'h1234});
    t_read(1, 1, {2'b01, 2'b10, 5'd5, 5'd2, 2'b10, 16'h0}, 16'hBEEF);
    t_read(0, 0, {2'b01, 2'b10, 5'd31, 5'd0, 2'b10, 16'hFFFF}, 16'h0F31);
    t_busy_ignore({2'b01, 2'b01, 5'd1, 5'd1, 2'b10, 16'h5A5A},
                  {2'b01, 2'b01, 5'd2, 5'd2, 2'b10, 16'hFFFF});
    t_write(0, 26, {2'b01, 2'b01, 5'd0, 5'd4, 2'b10, 16'h8001});
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule